// File: doc/BRIEF.md
# Dual-Mode UART Baud Tick Generator

This block derives the two timing strobes a UART needs from the system clock. A 16-bit divisor sets the period of a free-running timer to divisor + 1 clocks. Each time that timer reaches its terminal count, the block emits a one-cycle sample strobe, which is the clock enable for oversampling. A small sub-counter groups these sample strobes into bit periods. In standard mode a bit lasts 16 sample strobes, and in fast mode it lasts 4.

Software loads the divisor through a write strobe with 16-bit data. Every write restarts both counters, so the new rate applies from the next cycle. Nothing waits for the old period to run out. When the mode input changes, only the sub-counter restarts, so no partial bit from the old mode carries over. For example, a 7.5 MHz clock with a divisor of 48 in standard mode gives a 784-clock bit period, which is about 9566 baud.

Top module: `uart_tick_gen`

## Requirements
- R1: While `rst` is high, neither tick is asserted. The first cycle after `rst` falls behaves as if divisor 0 and standard mode had just been loaded.
- R2: Let D be the divisor and n the number of cycles since the edge that loaded it. `sample_tick` is a one-cycle pulse high exactly when n mod (D+1) = D.
- R3: In standard mode (`fast_mode` = 0), `bit_tick` is high exactly when n mod 16(D+1) = 16(D+1)-1.
- R4: In fast mode (`fast_mode` = 1), `bit_tick` is high exactly when n mod 4(D+1) = 4(D+1)-1.
- R5: `bit_tick` is high only in a cycle where `sample_tick` is also high.
- R6: Any write restarts timing. The cycle after the write edge is n = 0, whatever phase the old count had reached.
- R7: In a cycle with `div_wr` high, neither tick is asserted, even when the timer is at terminal count.
- R8: In the cycle `fast_mode` differs from its registered value, `bit_tick` stays low and the sub-counter restarts. The next bit tick then comes on the L-th sample tick that follows, where L is the new mode's ratio. The timer phase is not disturbed.
- R9: A divisor of 0 gives a sample tick every cycle. A divisor of 65535 gives a sample period of 65536 cycles.
- R10: A divisor of 48 in standard mode gives a bit period of 784 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_wr | input | 1 | Divisor write strobe |
| div_data | input | 16 | Divisor value written when `div_wr` is high |
| fast_mode | input | 1 | 0: 16 samples per bit, 1: 4 samples per bit |
| sample_tick | output | 1 | Oversampling clock-enable pulse |
| bit_tick | output | 1 | One pulse per bit period |

## Verification
The two counters show up at the ports within one sample period or one bit period. A timer phase error moves the very next `sample_tick`. A sub-counter that is not cleared, or that wraps at the wrong value, moves the next `bit_tick` by a whole number of sample periods. The bench therefore sweeps small divisors in both modes across several bit periods and compares every cycle with the arithmetic position. It then drives the write-at-terminal-count collision, a mode change in mid-bit, and both extreme divisors.

// File: rtl/uart_tick_pkg.sv
package uart_tick_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FAST = 1'b1
    } rate_mode_e;

    localparam int unsigned OVS_STD  = 16;
    localparam int unsigned OVS_FAST = 4;
endpackage

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wr_data,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [DIV_W-1:0] cnt;
    } tmr_s;

    tmr_s st_d, st_q;
    logic at_tc;

    always_comb begin
        st_d   = st_q;
        at_tc  = (st_q.cnt == st_q.div);
        tick_o = at_tc && !wr_en && !rst;
        if (wr_en) begin
            st_d.div = wr_data;
            st_d.cnt = '0;
        end else if (at_tc) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R1
    a_r1_quiet_in_reset: assert property (@(posedge clk) rst |-> !tick_o);
    // R2
    a_r2_no_overrun: assert property (@(posedge clk) disable iff (rst)
        st_q.cnt <= st_q.div);
    // R6
    a_r6_write_clears: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (st_q.cnt == '0));
    // R7
    a_r7_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !tick_o);
endmodule

// File: rtl/tick_subdiv.sv
module tick_subdiv
    import uart_tick_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr_i,
    input  logic       sample_i,
    input  rate_mode_e mode_i,
    output logic       bit_o
);
    localparam int unsigned SUB_W = $clog2(OVS_STD);
    localparam logic [SUB_W-1:0] STD_LAST  = SUB_W'(OVS_STD - 1);
    localparam logic [SUB_W-1:0] FAST_LAST = SUB_W'(OVS_FAST - 1);

    typedef struct packed {
        rate_mode_e       mode;
        logic [SUB_W-1:0] sub;
    } sub_s;

    sub_s st_d, st_q;
    logic mode_chg;
    logic [SUB_W-1:0] last;
    logic wrap;

    always_comb begin
        st_d     = st_q;
        mode_chg = (mode_i != st_q.mode);
        last     = (st_q.mode == MODE_FAST) ? FAST_LAST : STD_LAST;
        wrap     = (st_q.sub >= last);
        bit_o    = sample_i && wrap && !mode_chg && !clr_i;
        st_d.mode = mode_i;
        if (clr_i || mode_chg) begin
            st_d.sub = '0;
        end else if (sample_i) begin
            st_d.sub = wrap ? '0 : st_q.sub + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{mode: MODE_STD, sub: '0};
        else     st_q <= st_d;
    end

    // R5
    a_r5_bit_on_sample: assert property (@(posedge clk) disable iff (rst)
        bit_o |-> sample_i);
    // R8
    a_r8_mode_change_clears: assert property (@(posedge clk) disable iff (rst)
        (mode_i != st_q.mode) |=> (st_q.sub == '0));
    // R4
    a_r4_fast_bound: assert property (@(posedge clk) disable iff (rst)
        (st_q.mode == MODE_FAST) |-> (st_q.sub <= FAST_LAST));
endmodule

// File: rtl/uart_tick_gen.sv
module uart_tick_gen
    import uart_tick_pkg::*;
#(
    parameter int unsigned DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             div_wr,
    input  logic [DIV_W-1:0] div_data,
    input  logic             fast_mode,
    output logic             sample_tick,
    output logic             bit_tick
);
    logic smp;
    rate_mode_e mode_sel;

    assign mode_sel = rate_mode_e'(fast_mode);

    tick_timer #(.DIV_W(DIV_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (div_wr),
        .wr_data (div_data),
        .tick_o  (smp)
    );

    tick_subdiv u_subdiv (
        .clk      (clk),
        .rst      (rst),
        .clr_i    (div_wr),
        .sample_i (smp),
        .mode_i   (mode_sel),
        .bit_o    (bit_tick)
    );

    assign sample_tick = smp;

    // R1
    a_r1_no_bit_in_reset: assert property (@(posedge clk) rst |-> !bit_tick);
endmodule

// File: tb/uart_tick_gen_bench.sv
`timescale 1ns/1ps
module uart_tick_gen_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic div_wr = 1'b0;
    logic [15:0] div_data = '0;
    logic fast_mode = 1'b0;
    logic sample_tick, bit_tick;
    int n_chk = 0;
    int n_err = 0;

    uart_tick_gen u_uart_tick_gen (
        .clk(clk), .rst(rst), .div_wr(div_wr), .div_data(div_data),
        .fast_mode(fast_mode), .sample_tick(sample_tick), .bit_tick(bit_tick)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_div(input int d, input logic m);
        @(negedge clk);
        div_wr = 1'b1;
        div_data = 16'(d);
        fast_mode = m;
    endtask

    task automatic run(input string tag, input int d, input logic m, input int n0, input int len);
        int per = d + 1;
        int bp  = (m ? 4 : 16) * per;
        for (int n = n0; n < len; n++) begin
            @(negedge clk);
            div_wr = 1'b0;
            #1;
            check({tag, " R2 sample"}, sample_tick, (n % per) == d);
            check({tag, m ? " R4 bit" : " R3 bit"}, bit_tick, (n % bp) == bp - 1);
            check({tag, " R5"}, bit_tick & ~sample_tick, 1'b0);
        end
    endtask

    initial begin
        #(20 * 200000);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1: quiet during reset
        repeat (3) begin
            @(negedge clk);
            #1;
            check("R1 sample in reset", sample_tick, 1'b0);
            check("R1 bit in reset", bit_tick, 1'b0);
        end
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 first sample after reset", sample_tick, 1'b1);
        check("R1 first bit after reset", bit_tick, 1'b0);
        run("R1", 0, 1'b0, 1, 40);

        // R6: sweep; each write lands mid-period of the previous run
        for (int d = 0; d < 6; d++) begin
            for (int m = 0; m < 2; m++) begin
                write_div(d, m[0]);
                run("R6", d, m[0], 0, 3 * (m ? 4 : 16) * (d + 1) + 2);
            end
        end

        // R7: write collides with terminal count
        write_div(3, 1'b0);
        run("R7 pre", 3, 1'b0, 0, 3);
        @(negedge clk);
        div_wr = 1'b1;
        div_data = 16'd2;
        #1;
        check("R7 sample on write", sample_tick, 1'b0);
        check("R7 bit on write", bit_tick, 1'b0);
        run("R7 post", 2, 1'b0, 0, 100);

        // R8: mode change in mid-bit
        write_div(1, 1'b0);
        run("R8 pre", 1, 1'b0, 0, 5);
        @(negedge clk);
        fast_mode = 1'b1;
        #1;
        check("R8 sample at change", sample_tick, 1'b1);
        check("R8 bit suppressed", bit_tick, 1'b0);
        for (int n = 6; n < 14; n++) begin
            @(negedge clk);
            #1;
            check("R8 sample", sample_tick, (n % 2) == 1);
            check("R8 bit", bit_tick, n == 13);
        end

        // R10: divisor 48 standard
        write_div(48, 1'b0);
        run("R10", 48, 1'b0, 0, 2 * 784 + 2);

        // R9: extremes
        write_div(0, 1'b1);
        run("R9 fastest", 0, 1'b1, 0, 20);
        write_div(65535, 1'b1);
        run("R9 slowest", 65535, 1'b1, 0, 65540);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule